// File: doc/BRIEF.md
# Full-Speed Serial Bus Bit Receiver

This block turns an oversampled differential pair (D+/D-) into received bytes. A phase accumulator sets the sampling rate. Every transition on the pair clears the accumulator's phase. Between transitions the accumulator runs freely. Each bit is sampled where the phase crosses half scale, which is half a bit period after the last realignment or rollover. The sampled line state is NRZI-decoded. The receiver then finds the start pattern, strips stuffed bits, packs bits into bytes least significant bit first, and detects end-of-packet, stuff, alignment and line errors.

The consumer sees one output bus. On a byte strobe it carries the received byte. On every other cycle it carries the current line status: whether a packet is open, and the synchronised line code. One-cycle strobes mark packet start, each byte and packet end. The end strobe carries an error code. CRC checking, PID parsing and transmission belong to the logic downstream.

Top module: `usb_fs_receiver`

## Requirements
- R1: When no byte strobe is present, `rx_data` shows the line status: bit 2 is 1 while a packet is open, and bits 1:0 are the synchronised line code {D-, D+}, where 0 = SE0, 1 = J, 2 = K and 3 = SE1. After reset with J on the pins and no packet open, the value is 8'h01.
- R2: Any change of the synchronised line state clears the sampling phase. The next sample falls half a bit period later, at bit centre.
- R3: With no transitions, the phase keeps running and wraps once per bit. A run of six unchanged bits followed by the stuffed bit still decodes correctly.
- R4: NRZI decoding gives a 1 for a sample equal to the previous J/K sample and a 0 for a changed one.
- R5: While no packet is open, the decoded sequence 0,0,0,0,0,0,0,1 (line K J K J K J K K starting from J) opens a packet, pulses `rx_start`, and clears the bit count.
- R6: Data bits are packed least significant bit first. Each eighth bit pulses `rx_valid` for one cycle, with the byte on `rx_data` and `rx_err` = 0.
- R7: The stuffing run counts consecutive ones, including the final 1 of the start pattern. The bit that follows six consecutive ones is dropped when it is a 0.
- R8: If the bit that follows six ones is a 1, the packet closes with `rx_end` and `rx_err` = 1. Later line activity is ignored until the next start pattern.
- R9: SE0 for one or more sampled bits, followed by a J sample, closes the packet with `rx_end` and `rx_err` = 0. `rx_end` rises no more than one bit period plus 4 clocks after J appears on the pins.
- R10: If the bit count is not a multiple of 8 at end-of-packet, `rx_end` carries `rx_err` = 2.
- R11: Either of two line faults closes the packet with `rx_err` = 3: an SE0 followed by a K sample, or an SE1 sample while a packet is open.
- R12: The per-clock phase increment `bit_inc` sets the bit rate. 2^32 divided by the number of clocks per bit gives correct reception at any rate of at least 8 clocks per bit.
- R13: At most one of `rx_start`, `rx_valid` and `rx_end` is high in any cycle. `rx_err` is 0 whenever `rx_end` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_i | input | 1 | D+ line, asynchronous |
| dm_i | input | 1 | D- line, asynchronous |
| bit_inc | input | PHASE_W | Phase increment per clock |
| rx_valid | output | 1 | Byte strobe |
| rx_data | output | 8 | Byte on strobe, otherwise line status |
| rx_start | output | 1 | Packet opened |
| rx_end | output | 1 | Packet closed |
| rx_err | output | 2 | Error code, valid with `rx_end` |

## Verification
The bench builds the block with its defaults: a 32-bit phase, a two-stage synchroniser and a stuffing limit of six. It runs at 8 clocks per bit and later at 9 clocks per bit, which exercises both the half-scale sample crossing and free-running across stuffed runs at two increment values. The end-of-packet latency bound is measured from the cycle the bench drives J. The bench covers the single-bit SE0 case, the partial-byte case, both line-fault cases, and activity after a stuff error.

// File: rtl/usbrx_pkg.sv
`timescale 1ns/1ps
package usbrx_pkg;
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_STUFF = 2'd1,
    ERR_ALIGN = 2'd2,
    ERR_LINE  = 2'd3
  } rxerr_t;

  localparam int SYNC_LEN = 8;
  // Decoded start pattern, newest bit in the MSB: seven zeros then a one.
  localparam logic [SYNC_LEN-1:0] SYNC_CODE = {1'b1, {(SYNC_LEN-1){1'b0}}};
endpackage

// File: rtl/usbrx_sync.sv
`timescale 1ns/1ps
module usbrx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/usbrx_nco.sv
`timescale 1ns/1ps
module usbrx_nco #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         line_i,
  input  logic [PHASE_W-1:0] inc_i,
  output logic               sample_o
);
  localparam int MSB = PHASE_W - 1;

  logic [PHASE_W-1:0] phase_q, phase_n;
  logic [1:0]         line_d_q;
  logic               stb_q, stb_n;
  logic               realign;

  always_comb begin
    realign = (line_i != line_d_q);
    phase_n = realign ? '0 : phase_q + inc_i;
    // Sample where the phase climbs through half scale.
    stb_n   = !phase_q[MSB] && phase_n[MSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      line_d_q <= '0;
      stb_q    <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      line_d_q <= line_i;
      stb_q    <= stb_n;
    end
  end

  assign sample_o = stb_q;

  AST_REALIGN_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !sample_o); // R2
endmodule

// File: rtl/usbrx_bitproc.sv
`timescale 1ns/1ps
module usbrx_bitproc
  import usbrx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STUFF_LIMIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic [1:0]        line_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              start_o,
  output logic              end_o,
  output logic [1:0]        err_o,
  output logic              active_o
);
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int ONES_W = $clog2(STUFF_LIMIT + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [ONES_W-1:0] ONES_MAX = ONES_W'(STUFF_LIMIT);

  line_t                line;
  logic                 active_q, active_n;
  logic                 se0_q, se0_n;
  line_t                prev_q, prev_n;
  logic [SYNC_LEN-1:0]  hist_q, hist_n;
  logic [ONES_W-1:0]    ones_q, ones_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic [DATA_W-1:0]    sh_q, sh_n;
  logic                 valid_q, valid_n, start_q, start_n, end_q, end_n;
  rxerr_t               err_q, err_n;
  logic [DATA_W-1:0]    byte_q, byte_n;
  logic                 dbit;

  assign line = line_t'(line_i);

  always_comb begin
    active_n = active_q;
    se0_n    = se0_q;
    prev_n   = prev_q;
    hist_n   = hist_q;
    ones_n   = ones_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    byte_n   = byte_q;
    valid_n  = 1'b0;
    start_n  = 1'b0;
    end_n    = 1'b0;
    err_n    = ERR_NONE;
    dbit     = (line == prev_q);
    if (sample_i) begin
      if (!active_q) begin
        if (line == LN_SE0 || line == LN_SE1) begin
          hist_n = '1;
        end else begin
          prev_n = line;
          hist_n = {dbit, hist_q[SYNC_LEN-1:1]};
          if (hist_n == SYNC_CODE) begin
            active_n = 1'b1;
            start_n  = 1'b1;
            se0_n    = 1'b0;
            cnt_n    = '0;
            ones_n   = ONES_W'(1);
          end
        end
      end else if (line == LN_SE0) begin
        se0_n = 1'b1;
      end else if (se0_q || line == LN_SE1) begin
        active_n = 1'b0;
        se0_n    = 1'b0;
        end_n    = 1'b1;
        hist_n   = '1;
        prev_n   = LN_J;
        if (se0_q && line == LN_J)
          err_n = (cnt_q != '0) ? ERR_ALIGN : ERR_NONE;
        else
          err_n = ERR_LINE;
      end else begin
        prev_n = line;
        if (ones_q == ONES_MAX) begin
          if (dbit) begin
            active_n = 1'b0;
            end_n    = 1'b1;
            err_n    = ERR_STUFF;
            hist_n   = '1;
          end else begin
            ones_n = '0;
          end
        end else begin
          sh_n   = {dbit, sh_q[DATA_W-1:1]};
          cnt_n  = cnt_q + 1'b1;
          ones_n = dbit ? ones_q + 1'b1 : '0;
          if (cnt_q == LAST_BIT) begin
            valid_n = 1'b1;
            byte_n  = sh_n;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      se0_q    <= 1'b0;
      prev_q   <= LN_J;
      hist_q   <= '1;
      ones_q   <= '0;
      cnt_q    <= '0;
      sh_q     <= '0;
      byte_q   <= '0;
      valid_q  <= 1'b0;
      start_q  <= 1'b0;
      end_q    <= 1'b0;
      err_q    <= ERR_NONE;
    end else begin
      active_q <= active_n;
      se0_q    <= se0_n;
      prev_q   <= prev_n;
      hist_q   <= hist_n;
      ones_q   <= ones_n;
      cnt_q    <= cnt_n;
      sh_q     <= sh_n;
      byte_q   <= byte_n;
      valid_q  <= valid_n;
      start_q  <= start_n;
      end_q    <= end_n;
      err_q    <= err_n;
    end
  end

  assign valid_o  = valid_q;
  assign data_o   = byte_q;
  assign start_o  = start_q;
  assign end_o    = end_q;
  assign err_o    = err_q;
  assign active_o = active_q;

  AST_ONES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= ONES_MAX); // R7
  AST_BYTE_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(active_q)); // R6
  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> active_q); // R5
  AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> !active_q && $past(active_q)); // R9
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_q, valid_q, end_q})); // R13
  AST_ERR_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != ERR_NONE) |-> end_q); // R13
endmodule

// File: rtl/usb_fs_receiver.sv
`timescale 1ns/1ps
module usb_fs_receiver #(
  parameter int PHASE_W     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int STUFF_LIMIT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dp_i,
  input  logic               dm_i,
  input  logic [PHASE_W-1:0] bit_inc,
  output logic               rx_valid,
  output logic [7:0]         rx_data,
  output logic               rx_start,
  output logic               rx_end,
  output logic [1:0]         rx_err
);
  localparam int DATA_W = 8;

  logic [1:0]        line_s;
  logic              sample;
  logic              active;
  logic [DATA_W-1:0] byte_d;

  usbrx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({dm_i, dp_i}), .q_o(line_s)
  );

  usbrx_nco #(.PHASE_W(PHASE_W)) u_nco (
    .clk(clk), .rst_n(rst_n), .line_i(line_s), .inc_i(bit_inc), .sample_o(sample)
  );

  usbrx_bitproc #(.DATA_W(DATA_W), .STUFF_LIMIT(STUFF_LIMIT)) u_bits (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .line_i(line_s),
    .valid_o(rx_valid), .data_o(byte_d), .start_o(rx_start),
    .end_o(rx_end), .err_o(rx_err), .active_o(active)
  );

  always_comb begin
    if (rx_valid) rx_data = byte_d;
    else          rx_data = {5'd0, active, line_s};
  end

  AST_STATUS_NOT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !active) |-> rx_data[7:2] == 6'd0); // R1
endmodule

// File: tb/tb_usb_fs_receiver.sv
`timescale 1ns/1ps
module tb_usb_fs_receiver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dp, dm;
  logic [31:0] inc;
  logic        rx_valid, rx_start, rx_end;
  logic [7:0]  rx_data;
  logic [1:0]  rx_err;

  int checks = 0, errors = 0;
  int cyc = 0, eop_j_cyc = 0, cpb = 8, ones = 0;
  logic cur_k = 1'b0;
  logic [9:0] exp_q[$];   // {kind, data}: 0 start, 1 byte, 2 end(code)
  string tag = "R6";
  bit done = 0;

  always #4 clk = ~clk;

  usb_fs_receiver dut (
    .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm), .bit_inc(inc),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_start(rx_start),
    .rx_end(rx_end), .rx_err(rx_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic drive(input logic [1:0] code);
    {dm, dp} = code;
    repeat (cpb) @(negedge clk);
  endtask

  task automatic tx_nrzi(input logic d);
    if (!d) cur_k = ~cur_k;
    drive(cur_k ? 2'b10 : 2'b01);
  endtask

  task automatic tx_data(input logic d, input bit stuff);
    tx_nrzi(d);
    ones = d ? ones + 1 : 0;
    if (stuff && ones == 6) begin tx_nrzi(1'b0); ones = 0; end
  endtask

  task automatic tx_sync();
    exp_q.push_back({2'd0, 8'h00});
    cur_k = 1'b0;
    for (int i = 0; i < 7; i++) tx_nrzi(1'b0);
    tx_nrzi(1'b1);
    ones = 1;
  endtask

  task automatic tx_byte(input logic [7:0] b, input bit stuff, input bit expect_it);
    if (expect_it) exp_q.push_back({2'd1, b});
    for (int i = 0; i < 8; i++) tx_data(b[i], stuff);
  endtask

  task automatic tx_eop(input int n_se0, input bit status_chk);
    for (int i = 0; i < n_se0; i++) begin
      {dm, dp} = 2'b00;
      repeat (cpb / 2 + 2) @(negedge clk);
      if (status_chk && i == 0)
        chk(rx_data == 8'h04 && !rx_valid, "R1 status during SE0", rx_data, 8'h04);
      repeat (cpb - cpb / 2 - 2) @(negedge clk);
    end
    eop_j_cyc = cyc;
    cur_k = 1'b0;
    drive(2'b01);
    drive(2'b01);
  endtask

  task automatic idle(input int n);
    cur_k = 1'b0;
    for (int i = 0; i < n; i++) drive(2'b01);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (rx_start || rx_valid || rx_end) begin
        chk($onehot0({rx_start, rx_valid, rx_end}), "R13 one event per cycle",
            {rx_start, rx_valid, rx_end}, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R13 unexpected event", {rx_start, rx_valid, rx_end, rx_data}, 0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          if (e[9:8] == 2'd0) begin
            chk(rx_start, "R5 packet start", {rx_valid, rx_end}, 0);
          end else if (e[9:8] == 2'd1) begin
            chk(rx_valid && rx_data == e[7:0] && rx_err == 2'd0,
                {tag, " R4 byte"}, {rx_valid, rx_data}, {1'b1, e[7:0]});
          end else begin
            string r;
            case (e[1:0])
              2'd0: r = "R9 clean end";
              2'd1: r = "R8 stuff error";
              2'd2: r = "R10 align error";
              default: r = "R11 line error";
            endcase
            chk(rx_end && rx_err == e[1:0], r, {rx_end, rx_err}, {1'b1, e[1:0]});
            if (e[1:0] == 2'd0)
              chk(cyc - eop_j_cyc <= cpb + 4, "R9 end latency", cyc - eop_j_cyc, cpb + 4);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dp = 1'b1; dm = 1'b0;
    inc = 32'h2000_0000;   // 8 clocks per bit
    repeat (5) @(negedge clk);
    chk(!rx_valid && !rx_start && !rx_end, "R1 reset outputs", {rx_valid, rx_start, rx_end}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(rx_data == 8'h01, "R1 idle line status", rx_data, 8'h01);
    idle(4);

    // Basic packet, edge-realigned sampling
    tag = "R2 R6";
    tx_sync();
    tx_byte(8'hA5, 1, 1); tx_byte(8'h3C, 1, 1); tx_byte(8'h00, 1, 1);
    exp_q.push_back({2'd2, 8'd0});
    tx_eop(2, 1);
    idle(3);

    // Long runs of ones with stuffing, free-running phase
    tag = "R3 R7";
    tx_sync();
    tx_byte(8'hFF, 1, 1); tx_byte(8'h7E, 1, 1); tx_byte(8'hFF, 1, 1); tx_byte(8'h81, 1, 1);
    exp_q.push_back({2'd2, 8'd0});
    tx_eop(1, 0);
    idle(3);

    // Stuff error: ones without the inserted zero; rest ignored
    tag = "R8";
    exp_q.push_back({2'd0, 8'h00});
    exp_q.push_back({2'd2, 8'd1});
    cur_k = 1'b0;
    for (int i = 0; i < 7; i++) tx_nrzi(1'b0);
    tx_nrzi(1'b1); ones = 1;
    tx_byte(8'hFF, 0, 0);
    tx_byte(8'h55, 0, 0);
    tx_eop(2, 0);
    idle(3);
    chk(rx_data == 8'h01, "R8 idle after stuff error", rx_data, 8'h01);

    // Partial byte at end
    tag = "R10";
    tx_sync();
    tx_byte(8'h5A, 1, 1);
    tx_data(1'b1, 1); tx_data(1'b0, 1); tx_data(1'b1, 1);
    exp_q.push_back({2'd2, 8'd2});
    tx_eop(2, 0);
    idle(3);

    // SE0 followed by K
    tag = "R11";
    tx_sync();
    tx_byte(8'h12, 1, 1);
    exp_q.push_back({2'd2, 8'd3});
    drive(2'b00); drive(2'b10);
    idle(4);

    // SE1 inside a packet
    tx_sync();
    tx_byte(8'hC3, 1, 1);
    exp_q.push_back({2'd2, 8'd3});
    drive(2'b11);
    idle(4);

    // Different bit rate set by the increment
    tag = "R12";
    cpb = 9;
    inc = 32'd477218589;
    idle(3);
    tx_sync();
    tx_byte(8'hE7, 1, 1); tx_byte(8'hFF, 1, 1); tx_byte(8'h01, 1, 1);
    exp_q.push_back({2'd2, 8'd0});
    tx_eop(2, 1);
    idle(4);

    chk(exp_q.size() == 0, "R6 all expected events seen", exp_q.size(), 0);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule